// File: doc/BRIEF.md
# Dual DAC Load and Transfer Logic

This block is the register-side front end for a pair of digital-to-analog converter channels. A narrow bus writes each channel's value into a holding register, one byte at a time or as a whole 16-bit word. The value reaches the channel's output register, which drives the converter, under one of two update policies chosen by a strap input. In per-channel mode, writing the upper byte of a channel moves that channel's value to its output. In simultaneous mode, bus writes only fill the holding registers, and a later bus read of any converter address moves both channels to their outputs on the same clock edge.

A shared register holds a 2-bit output-range code for each channel. A build parameter selects a 16-bit or a 12-bit converter. In the 12-bit build the value is left-justified in the 16-bit bus word and the lowest four bits are dropped. The converter codes and range codes come out as plain ports. Conversion itself and reference switching are handled elsewhere.

Top module: `dual_dac_loader`

## Requirements
- R1: After reset both output codes and both holding registers are zero, and both range codes are 2.
- R2: Channel n has its low byte at address 4+2n and its high byte at address 5+2n. A write to any other address, apart from the range register, changes no holding register, no output code and no range code.
- R3: A byte write (bus_word=0) takes its data from bus_wdata[7:0]. At the low-byte address it sets holding bits [7:0], and at the high-byte address it sets holding bits [15:8]. Software is expected to write the low byte first.
- R4: With strap_simul=0, a high-byte write, or a word write to the low-byte address, sets that channel's output code to the updated holding value at the next clock edge. A low-byte write alone leaves the output unchanged.
- R5: With strap_simul=1, writes never change an output code. A read (bus_rd=1, bus_wr=0) of any address from 4 to 7 sets both output codes to their holding values at the same clock edge.
- R6: With strap_simul=0, reads change no output code.
- R7: A word write (bus_word=1) to a low-byte address loads all 16 bits of bus_wdata into the holding register in one cycle.
- R8: With DATA_BITS=12, the output code is holding bits [15:4]. Holding bits [3:0] always read as zero, whatever was written there.
- R9: A write to address 10 sets the channel 0 range code from bus_wdata[5:4] and the channel 1 range code from bus_wdata[7:6]. The other bits of the write are ignored. Range codes mean 0: ±5 V, 1: ±10 V, 2: 0–5 V, 3: 0–10 V.
- R10: bus_rdata is combinational from bus_addr:
  - at a low-byte address it is the whole holding word;
  - at a high-byte address it is {8'h00, holding[15:8]};
  - at address 10 it is {8'h00, range1, range0, 4'h0};
  - at any other address it is zero.
  A read returns the holding value even when it also triggers a transfer.
- R11: A cycle with bus_wr and bus_rd both high is treated as a write only, and its read side triggers no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_simul | input | 1 | 1 = simultaneous update on read, 0 = per-channel update on write |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| dac0_code | output | DATA_BITS | Channel 0 converter code |
| dac1_code | output | DATA_BITS | Channel 1 converter code |
| dac0_range | output | 2 | Channel 0 range code |
| dac1_range | output | 2 | Channel 1 range code |

## Verification
A corrupted holding register shows on bus_rdata in the same cycle the address selects it. It also reaches a converter code one edge after the next transfer: a high-byte write in per-channel mode, or a read in simultaneous mode. A wrong transfer decision shows as a converter code that moves, or fails to move, on the edge that follows the access. So every access is followed by a compare of both codes, both range codes and the read data. Sweeps over both channels and many data patterns cover both builds (16-bit and 12-bit) side by side on a shared bus, so that a low-nibble leak or a swapped byte lane shows up in the same step that caused it.

// File: rtl/dacld_pkg.sv
package dacld_pkg;
  localparam int BUS_W  = 16;
  localparam int NCH    = 2;
  localparam int RNG_W  = 2;

  // Merge one access into a left-justified holding word.
  // lo_en : low byte from wd[7:0]
  // hi_en : high byte, from wd[15:8] for a word access, else wd[7:0]
  function automatic logic [BUS_W-1:0] merge_access(
      input logic [BUS_W-1:0] cur,
      input logic [BUS_W-1:0] wd,
      input logic             lo_en,
      input logic             hi_en,
      input logic             hi_upper);
    logic [BUS_W-1:0] r;
    r = cur;
    if (lo_en) r[7:0]  = wd[7:0];
    if (hi_en) r[15:8] = hi_upper ? wd[15:8] : wd[7:0];
    return r;
  endfunction

  // Keep only the converter's bits of a left-justified word.
  function automatic logic [BUS_W-1:0] justify_mask(input int bits);
    return {BUS_W{1'b1}} << (BUS_W - bits);
  endfunction
endpackage

// File: rtl/dacld_decode.sv
module dacld_decode
  import dacld_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BASE   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic              word,
  output logic [NCH-1:0]    lo_en,
  output logic [NCH-1:0]    hi_en,
  output logic [NCH-1:0]    hi_upper,
  output logic              dac_rd
);
  logic [NCH-1:0] in_win;

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(BASE + 2*n);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(BASE + 2*n + 1);
    assign lo_en[n]    = wr && (addr == LO_A);
    assign hi_upper[n] = word && (addr == LO_A);
    assign hi_en[n]    = wr && ((addr == HI_A) || ((addr == LO_A) && word));
    assign in_win[n]   = (addr == LO_A) || (addr == HI_A);
  end

  // Write has priority over read in the same cycle.
  assign dac_rd = rd && !wr && (|in_win);

  AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lo_en | hi_en)) else $error("two channels strobed"); // R2
endmodule

// File: rtl/dacld_chan.sv
module dacld_chan
  import dacld_pkg::*;
#(
  parameter int DATA_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lo_en,
  input  logic                 hi_en,
  input  logic                 hi_upper,
  input  logic                 own_mode,
  input  logic                 commit_all,
  input  logic [BUS_W-1:0]     wdata,
  output logic [BUS_W-1:0]     hold_lj,
  output logic [DATA_BITS-1:0] out_code
);
  localparam logic [BUS_W-1:0] KEEP = justify_mask(DATA_BITS);

  logic [BUS_W-1:0] hold_next;
  logic             commit_own;

  assign hold_next  = merge_access(hold_lj, wdata, lo_en, hi_en, hi_upper) & KEEP;
  assign commit_own = own_mode && hi_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_lj  <= '0;
      out_code <= '0;
    end else begin
      hold_lj <= hold_next;
      if (commit_own || commit_all)
        out_code <= hold_next[BUS_W-1 -: DATA_BITS];
    end
  end

  AST_OWN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    commit_own |=> out_code == hold_lj[BUS_W-1 -: DATA_BITS]) else $error("own xfer"); // R4
  AST_ALL_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    commit_all |=> out_code == hold_lj[BUS_W-1 -: DATA_BITS]) else $error("sim xfer"); // R5
  AST_LOW_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_lj & ~KEEP) == '0) else $error("pad bits set"); // R8
endmodule

// File: rtl/dacld_range.sv
module dacld_range
  import dacld_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [NCH*RNG_W-1:0] fields,
  output logic [NCH*RNG_W-1:0] codes
);
  localparam logic [RNG_W-1:0] RNG_RESET = 2'd2;

  for (genvar n = 0; n < NCH; n++) begin : g_rng
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     codes[n*RNG_W +: RNG_W] <= RNG_RESET;
      else if (wr_en) codes[n*RNG_W +: RNG_W] <= fields[n*RNG_W +: RNG_W];
    end
  end
endmodule

// File: rtl/dual_dac_loader.sv
module dual_dac_loader
  import dacld_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_BITS  = 16,
  parameter int DAC_BASE   = 4,
  parameter int RANGE_ADDR = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 strap_simul,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic                 bus_word,
  input  logic [BUS_W-1:0]     bus_wdata,
  output logic [BUS_W-1:0]     bus_rdata,
  output logic [DATA_BITS-1:0] dac0_code,
  output logic [DATA_BITS-1:0] dac1_code,
  output logic [RNG_W-1:0]     dac0_range,
  output logic [RNG_W-1:0]     dac1_range
);
  localparam logic [ADDR_W-1:0] RNG_A = ADDR_W'(RANGE_ADDR);

  logic [NCH-1:0]       lo_en, hi_en, hi_upper;
  logic                 dac_rd, simul_xfer, rng_wr;
  logic [BUS_W-1:0]     hold_lj [NCH];
  logic [DATA_BITS-1:0] code    [NCH];
  logic [NCH*RNG_W-1:0] rng_codes;

  dacld_decode #(.ADDR_W(ADDR_W), .BASE(DAC_BASE)) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .word(bus_word), .lo_en(lo_en), .hi_en(hi_en), .hi_upper(hi_upper),
    .dac_rd(dac_rd)
  );

  assign simul_xfer = strap_simul && dac_rd;
  assign rng_wr     = bus_wr && (bus_addr == RNG_A);

  for (genvar n = 0; n < NCH; n++) begin : g_chan
    dacld_chan #(.DATA_BITS(DATA_BITS)) u_chan (
      .clk(clk), .rst_n(rst_n), .lo_en(lo_en[n]), .hi_en(hi_en[n]),
      .hi_upper(hi_upper[n]), .own_mode(!strap_simul), .commit_all(simul_xfer),
      .wdata(bus_wdata), .hold_lj(hold_lj[n]), .out_code(code[n])
    );
  end

  dacld_range u_rng (
    .clk(clk), .rst_n(rst_n), .wr_en(rng_wr), .fields(bus_wdata[7:4]),
    .codes(rng_codes)
  );

  assign dac0_code  = code[0];
  assign dac1_code  = code[1];
  assign dac0_range = rng_codes[1:0];
  assign dac1_range = rng_codes[3:2];

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == RNG_A) bus_rdata = {8'h00, rng_codes, 4'h0};
    for (int n = 0; n < NCH; n++) begin
      if (bus_addr == ADDR_W'(DAC_BASE + 2*n))     bus_rdata = hold_lj[n];
      if (bus_addr == ADDR_W'(DAC_BASE + 2*n + 1)) bus_rdata = {8'h00, hold_lj[n][15:8]};
    end
  end

  AST_SIM_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_simul && bus_wr) |=> ($stable(dac0_code) && $stable(dac1_code)))
    else $error("write moved output in simultaneous mode"); // R5
  AST_OWN_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!strap_simul && !bus_wr) |=> ($stable(dac0_code) && $stable(dac1_code)))
    else $error("read moved output in per-channel mode"); // R6
  AST_RNG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == RNG_A) |=> ($stable(dac0_range) && $stable(dac1_range)))
    else $error("range moved without write"); // R9
  AST_WR_OVER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_rd && strap_simul) |=> ($stable(dac0_code) && $stable(dac1_code)))
    else $error("read side of write cycle acted"); // R11
endmodule

// File: tb/tb_dual_dac_loader.sv
`timescale 1ns/1ps
module tb_dual_dac_loader;
  logic        clk = 0, rst_n = 0, strap = 0;
  logic [3:0]  addr = 0;
  logic        wr = 0, rd = 0, word = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata, rdata12;
  logic [15:0] c0, c1;
  logic [11:0] d0, d1;
  logic [1:0]  r0, r1, s0, s1;

  int errors = 0, checks = 0;
  logic [15:0] h [2];
  logic [15:0] o [2];
  logic [1:0]  er [2];

  always #4 clk = ~clk;

  dual_dac_loader dut (
    .clk(clk), .rst_n(rst_n), .strap_simul(strap), .bus_addr(addr), .bus_wr(wr),
    .bus_rd(rd), .bus_word(word), .bus_wdata(wdata), .bus_rdata(rdata),
    .dac0_code(c0), .dac1_code(c1), .dac0_range(r0), .dac1_range(r1));

  dual_dac_loader #(.DATA_BITS(12)) dut12 (
    .clk(clk), .rst_n(rst_n), .strap_simul(strap), .bus_addr(addr), .bus_wr(wr),
    .bus_rd(rd), .bus_word(word), .bus_wdata(wdata), .bus_rdata(rdata12),
    .dac0_code(d0), .dac1_code(d1), .dac0_range(s0), .dac1_range(s1));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    chk({tag, " R4/R5 c0"}, c0, o[0]);
    chk({tag, " R4/R5 c1"}, c1, o[1]);
    chk({tag, " R8 d0"}, {4'h0, d0}, o[0] >> 4);
    chk({tag, " R8 d1"}, {4'h0, d1}, o[1] >> 4);
    chk({tag, " R9 rng"}, {12'h0, r1, r0}, {12'h0, er[1], er[0]});
    chk({tag, " R9 rng12"}, {12'h0, s1, s0}, {12'h0, er[1], er[0]});
  endtask

  function automatic logic [15:0] exp_rd(input logic [3:0] a, input logic [15:0] m);
    logic [15:0] v = 16'h0;
    if (a == 4'd10) v = {8'h00, er[1], er[0], 4'h0};
    for (int n = 0; n < 2; n++) begin
      if (a == 4'(4 + 2*n)) v = h[n] & m;
      if (a == 4'(5 + 2*n)) v = {8'h00, h[n][15:8] & m[15:8]};
    end
    return v;
  endfunction

  // One bus cycle; model follows the requirements.
  task automatic op(input string tag, input logic [3:0] a, input logic [15:0] d,
                    input logic w, input logic r, input logic wd);
    @(negedge clk);
    addr = a; wdata = d; wr = w; rd = r; word = wd;
    #1;
    chk({tag, " R10 rdata"}, rdata, exp_rd(a, 16'hFFFF));
    chk({tag, " R10 rdata12"}, rdata12, exp_rd(a, 16'hFFF0));
    if (w) begin
      for (int n = 0; n < 2; n++) begin
        if (a == 4'(4 + 2*n)) begin
          h[n][7:0] = d[7:0];
          if (wd) begin
            h[n][15:8] = d[15:8];
            if (!strap) o[n] = h[n];
          end
        end
        if (a == 4'(5 + 2*n)) begin
          h[n][15:8] = d[7:0];
          if (!strap) o[n] = h[n];
        end
      end
      if (a == 4'd10) begin er[0] = d[5:4]; er[1] = d[7:6]; end
    end else if (r && strap && a >= 4'd4 && a <= 4'd7) begin
      o[0] = h[0]; o[1] = h[1];
    end
    @(negedge clk);
    wr = 0; rd = 0; word = 0;
    check_state(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    h[0] = 0; h[1] = 0; o[0] = 0; o[1] = 0; er[0] = 2; er[1] = 2;
    repeat (3) @(negedge clk);
    check_state("R1 reset");
    rst_n = 1;
    @(negedge clk);
    check_state("R1 after release");
    for (int a = 4; a < 8; a++) op("R1 readback", 4'(a), 0, 0, 1, 0);

    // Per-channel mode: byte pairs, R3 R4 R2 R8
    for (int ch = 0; ch < 2; ch++)
      for (int k = 0; k < 24; k++) begin
        logic [15:0] v = 16'(k * 16'h2B79 + ch * 16'h1357 + 16'h0F0F);
        op("R3 lo byte", 4'(4 + 2*ch), {8'hEE, v[7:0]}, 1, 0, 0);
        op("R4 hi byte", 4'(5 + 2*ch), {8'hDD, v[15:8]}, 1, 0, 0);
        op("R10 read lo", 4'(4 + 2*ch), 0, 0, 1, 0);
        op("R6 read hi", 4'(5 + 2*ch), 0, 0, 1, 0);
      end
    // Word writes, R7
    for (int k = 0; k < 16; k++)
      op("R7 word", 4'(4 + 2*(k % 2)), 16'(k * 16'h1111 ^ 16'hA5C3), 1, 0, 1);
    // Stray addresses, R2
    for (int a = 0; a < 16; a++)
      if (a < 4 || a == 8 || a == 9 || a > 10) begin
        op("R2 stray word", 4'(a), 16'hFFFF, 1, 0, 1);
        op("R2 stray byte", 4'(a), 16'h5A5A, 1, 0, 0);
      end
    // Range register, all codes, R9
    for (int v = 0; v < 16; v++) begin
      op("R9 range wr", 4'd10, 16'(16'hAB0F | (v << 4)), 1, 0, 0);
      op("R9 range rd", 4'd10, 0, 0, 1, 0);
    end

    // Simultaneous mode, R5 R11
    strap = 1;
    for (int k = 0; k < 8; k++) begin
      op("R5 load0", 4'd4, 16'(16'h3C96 + k * 16'h0731), 1, 0, 1);
      op("R5 load1 lo", 4'd6, 16'(16'h0012 + k), 1, 0, 0);
      op("R5 load1 hi", 4'd7, 16'(16'h0080 + k), 1, 0, 0);
      op("R11 wr+rd", 4'd5, 16'(16'h0044 + k), 1, 1, 0);
      op("R5 xfer rd", 4'(4 + (k % 4)), 0, 0, 1, 0);
    end
    op("R5 rd stray no xfer", 4'd4, 16'h1234, 1, 0, 1);
    op("R5 rd other addr", 4'd9, 0, 0, 1, 0);
    op("R5 rd range addr", 4'd10, 0, 0, 1, 0);
    op("R5 final xfer", 4'd7, 0, 0, 1, 0);

    // Back to per-channel mode: read must not move, R6
    strap = 0;
    op("R6 lo only", 4'd6, 16'h00C3, 1, 0, 0);
    op("R6 read", 4'd6, 0, 0, 1, 0);
    op("R4 commit", 4'd7, 16'h0019, 1, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule